// File: doc/BRIEF.md
# Multicast Hash Receive Filter

This block sits on the receive path of an Ethernet MAC and decides, for each incoming frame, whether the destination address passes the group-address hash filter. The six destination bytes arrive one per clock on a byte stream, and a start strobe marks the first byte. While the bytes arrive, a reflected CRC-32 is folded over them, one byte per clock. The top bits of the finished CRC form an index into a 64-bit hash table. That table is kept in four 16-bit words, which software loads through a simple write port.

One cycle after the sixth byte, the block pulses a decision strobe. With it come the accept flag and a flag telling whether the address was a group address. Two configuration inputs control the decision. One turns the hash filter on. The other turns on promiscuous acceptance. Both inputs, and the table contents, are captured when a frame starts, so a change made during a frame never affects that frame. Matching the station's own unicast address is done elsewhere. This block rejects unicast frames unless promiscuous acceptance is on.

Top module: `mcast_hash_filter`

## Requirements
- R1: The decision strobe `dec_valid` is high for exactly one cycle, the cycle after the clock edge that takes the sixth address byte. It is low at all other times.
- R2: The CRC starts at 0xFFFFFFFF. Each byte is fed least significant bit first. For each bit, the CRC bit 0 is XORed with the data bit, the CRC is shifted right by one, and 0xEDB88320 is XORed in when that XOR was 1. No final inversion is applied. The hash index is bits 31..26 of the result.
- R3: Index bits 5..4 select table word 0 to 3, and index bits 3..0 select the bit within that word. Word k therefore holds index values 16k to 16k+15. `tbl_sel` names the word being written.
- R4: The address is a group address when bit 0 of the first byte is 1. `dec_group` reports this along with the decision.
- R5: A group address is accepted when hashing is enabled and the table bit it selects is 1. When hashing is enabled and that bit is 0, the address is rejected.
- R6: With hashing disabled and promiscuous acceptance off, group addresses are rejected.
- R7: With promiscuous acceptance on, every frame is accepted, whatever the table holds.
- R8: A unicast address is rejected unless promiscuous acceptance is on.
- R9: If all four table words are 0xFFFF and hashing is enabled, every group address is accepted.
- R10: The table words and both configuration inputs are sampled in the cycle that carries the start strobe. A table write made during a frame applies from the next frame on.
- R11: Bytes that arrive after the sixth byte and before the next start strobe are ignored and produce no decision. A start strobe that arrives partway through an address abandons the old address and begins a new one.
- R12: After reset, `dec_valid` and `dec_accept` are 0, and all table words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_vld | input | 1 | An address byte is present |
| addr_sof | input | 1 | Marks the first address byte of a frame (qualified by addr_vld) |
| addr_byte | input | 8 | Destination address byte, first byte first |
| cfg_hash_en | input | 1 | Enable the group-address hash test |
| cfg_promisc | input | 1 | Accept every frame |
| tbl_we | input | 1 | Table word write strobe |
| tbl_sel | input | 2 | Table word number to write |
| tbl_wdata | input | 16 | Table word write data |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted (valid with dec_valid) |
| dec_group | output | 1 | Address is a group address (valid with dec_valid) |

## Verification
The only result that follows a byte is the decision. It appears one edge after the sixth byte, so the bench drives each byte on a falling edge. It reads dec_valid, dec_accept and dec_group on the falling edge that follows the sixth byte, and it also confirms that the strobe was low while the bytes were being driven. A table write takes one edge to land. The bench therefore finishes writes before the falling edge that drives the start byte, except in the write-during-frame test, where the later timing is the point of the test. For ignored trailing bytes, the strobe is read on the falling edge after each extra byte.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
   typedef struct packed {
      logic hash_en;
      logic promisc;
   } mhf_cfg_t;
endpackage

// File: rtl/mhf_crc_byte.sv
module mhf_crc_byte #(
   parameter int unsigned          CRC_W = 32,
   parameter logic [CRC_W-1:0]     POLY  = 32'hEDB88320
) (
   input  logic [CRC_W-1:0] crc_in,
   input  logic [7:0]       data_in,
   output logic [CRC_W-1:0] crc_out
);
   logic [8:0][CRC_W-1:0] stg;

   assign stg[0] = crc_in;

   for (genvar i = 0; i < 8; i++) begin : g_bit
      logic fb;
      assign fb         = stg[i][0] ^ data_in[i];
      assign stg[i+1]   = {1'b0, stg[i][CRC_W-1:1]} ^ (fb ? POLY : '0);
   end

   assign crc_out = stg[8];
endmodule

// File: rtl/mhf_addr_track.sv
module mhf_addr_track #(
   parameter int unsigned      ADDR_BYTES = 6,
   parameter int unsigned      CRC_W      = 32,
   parameter int unsigned      IDX_W      = 6,
   parameter logic [CRC_W-1:0] POLY       = 32'hEDB88320,
   parameter logic [CRC_W-1:0] INIT       = 32'hFFFFFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_vld,
   input  logic             byte_sof,
   input  logic [7:0]       byte_in,
   output logic             sof,
   output logic             last_beat,
   output logic             in_frame,
   output logic             group_now,
   output logic [IDX_W-1:0] hash_idx
);
   localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             in_frame_q;
   logic [CRC_W-1:0] crc_q, crc_src, crc_next;
   logic             group_q;
   logic             beat;

   always_comb begin
      sof       = byte_vld & byte_sof;
      beat      = sof | (byte_vld & in_frame_q);
      last_beat = beat & (sof ? (ADDR_BYTES == 1) : (cnt_q == CNT_W'(ADDR_BYTES - 1)));
      crc_src   = sof ? INIT : crc_q;
      group_now = sof ? byte_in[0] : group_q;
   end

   mhf_crc_byte #(.CRC_W(CRC_W), .POLY(POLY)) u_crc (
      .crc_in  (crc_src),
      .data_in (byte_in),
      .crc_out (crc_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         in_frame_q <= 1'b0;
         crc_q      <= INIT;
         group_q    <= 1'b0;
      end else begin
         if (sof)       cnt_q <= CNT_W'(1);
         else if (beat) cnt_q <= cnt_q + CNT_W'(1);
         if (last_beat) in_frame_q <= 1'b0;
         else if (sof)  in_frame_q <= 1'b1;
         if (beat)      crc_q   <= crc_next;
         if (sof)       group_q <= byte_in[0];
      end
   end

   assign in_frame = in_frame_q;
   assign hash_idx = crc_next[CRC_W-1 -: IDX_W];

   a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      in_frame_q |-> (cnt_q < CNT_W'(ADDR_BYTES)));
endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned NUM_WORDS = 4,
   parameter int unsigned IDX_W     = 6,
   parameter int unsigned SEL_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              snap,
   input  logic              frame_busy,
   input  logic [IDX_W-1:0]  idx,
   output logic              hit
);
   logic [NUM_WORDS-1:0][WORD_W-1:0] shadow_q, active_q, look;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shadow_q[w] <= '0;
            active_q[w] <= '0;
         end else begin
            if (wr_en && wr_sel == SEL_W'(w)) shadow_q[w] <= wr_data;
            if (snap)                         active_q[w] <= shadow_q[w];
         end
      end
   end

   always_comb begin
      look = snap ? shadow_q : active_q;
      hit  = look[idx / IDX_W'(WORD_W)][idx % IDX_W'(WORD_W)];
   end

   a_r10_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_busy && !snap) |=> $stable(active_q));
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
   import mhf_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned NUM_WORDS  = 4,
   parameter int unsigned CRC_W      = 32,
   parameter logic [31:0] CRC_POLY   = 32'hEDB88320,
   parameter logic [31:0] CRC_INIT   = 32'hFFFFFFFF,
   localparam int unsigned TBL_BITS  = WORD_W * NUM_WORDS,
   localparam int unsigned IDX_W     = $clog2(TBL_BITS),
   localparam int unsigned SEL_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_vld,
   input  logic              addr_sof,
   input  logic [7:0]        addr_byte,
   input  logic              cfg_hash_en,
   input  logic              cfg_promisc,
   input  logic              tbl_we,
   input  logic [SEL_W-1:0]  tbl_sel,
   input  logic [WORD_W-1:0] tbl_wdata,
   output logic              dec_valid,
   output logic              dec_accept,
   output logic              dec_group
);
   if (CRC_W != 32) begin : g_bad_crc
      $error("mcast_hash_filter: CRC_W must be 32");
   end
   if ((1 << IDX_W) != TBL_BITS) begin : g_bad_tbl
      $error("mcast_hash_filter: table size must be a power of two");
   end
   if (IDX_W > CRC_W || ADDR_BYTES < 1) begin : g_bad_idx
      $error("mcast_hash_filter: bad index width or address length");
   end

   logic             sof, last_beat, in_frame, group_now, hit;
   logic [IDX_W-1:0] hash_idx;
   mhf_cfg_t         cfg_live, cfg_q, cfg_use;
   logic             dec_valid_q, dec_accept_q, dec_group_q;

   mhf_addr_track #(
      .ADDR_BYTES (ADDR_BYTES), .CRC_W (CRC_W), .IDX_W (IDX_W),
      .POLY (CRC_POLY), .INIT (CRC_INIT)
   ) u_track (
      .clk (clk), .rst_n (rst_n),
      .byte_vld (addr_vld), .byte_sof (addr_sof), .byte_in (addr_byte),
      .sof (sof), .last_beat (last_beat), .in_frame (in_frame),
      .group_now (group_now), .hash_idx (hash_idx)
   );

   mhf_hash_table #(
      .WORD_W (WORD_W), .NUM_WORDS (NUM_WORDS), .IDX_W (IDX_W), .SEL_W (SEL_W)
   ) u_table (
      .clk (clk), .rst_n (rst_n),
      .wr_en (tbl_we), .wr_sel (tbl_sel), .wr_data (tbl_wdata),
      .snap (sof), .frame_busy (in_frame), .idx (hash_idx), .hit (hit)
   );

   always_comb begin
      cfg_live.hash_en = cfg_hash_en;
      cfg_live.promisc = cfg_promisc;
      cfg_use          = sof ? cfg_live : cfg_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q        <= '0;
         dec_valid_q  <= 1'b0;
         dec_accept_q <= 1'b0;
         dec_group_q  <= 1'b0;
      end else begin
         if (sof) cfg_q <= cfg_live;
         dec_valid_q <= last_beat;
         if (last_beat) begin
            dec_accept_q <= cfg_use.promisc | (group_now & cfg_use.hash_en & hit);
            dec_group_q  <= group_now;
         end
      end
   end

   assign dec_valid  = dec_valid_q;
   assign dec_accept = dec_accept_q;
   assign dec_group  = dec_group_q;

   a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat |=> dec_valid);
   if (ADDR_BYTES > 1) begin : g_pulse_chk
      a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
         dec_valid |=> !dec_valid);
   end
   a_r7_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
      (last_beat && cfg_use.promisc) |=> dec_accept);
   a_r8_unicast_rejected: assert property (@(posedge clk) disable iff (!rst_n)
      (last_beat && !group_now && !cfg_use.promisc) |=> !dec_accept);
   a_r6_hash_off_rejects: assert property (@(posedge clk) disable iff (!rst_n)
      (last_beat && !cfg_use.hash_en && !cfg_use.promisc) |=> !dec_accept);
   a_r11_no_stray_decision: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_frame && !sof) |=> !dec_valid);
endmodule

// File: tb/tb_mcast_hash_filter.sv
module tb_mcast_hash_filter;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        addr_vld, addr_sof;
   logic [7:0]  addr_byte;
   logic        cfg_hash_en, cfg_promisc;
   logic        tbl_we;
   logic [1:0]  tbl_sel;
   logic [15:0] tbl_wdata;
   logic        dec_valid, dec_accept, dec_group;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   mcast_hash_filter dut (
      .clk (clk), .rst_n (rst_n),
      .addr_vld (addr_vld), .addr_sof (addr_sof), .addr_byte (addr_byte),
      .cfg_hash_en (cfg_hash_en), .cfg_promisc (cfg_promisc),
      .tbl_we (tbl_we), .tbl_sel (tbl_sel), .tbl_wdata (tbl_wdata),
      .dec_valid (dec_valid), .dec_accept (dec_accept), .dec_group (dec_group)
   );

   // vector: {addr[47:0] (first byte in 47:40), table[63:0] (word k = bits 16k+15..16k), hash_en, promisc}
   localparam int NV = 9;
   localparam logic [113:0] VEC [NV] = '{
      {48'h01005E000001, 64'h0000_0000_0000_0000, 1'b1, 1'b0},
      {48'h01005E000001, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0},
      {48'h333300000001, 64'hA5A5_5A5A_0F0F_F0F0, 1'b1, 1'b0},
      {48'hFFFFFFFFFFFF, 64'h5A5A_A5A5_F0F0_0F0F, 1'b1, 1'b0},
      {48'h0180C2000000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0},
      {48'h001122334455, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0},
      {48'h001122334455, 64'h0000_0000_0000_0000, 1'b0, 1'b1},
      {48'h09002B000004, 64'h0000_0000_0000_0000, 1'b0, 1'b1},
      {48'h0180C2000000, 64'h3C3C_C3C3_6666_9999, 1'b1, 1'b0}
   };

   function automatic logic [5:0] ref_idx(input logic [47:0] a);
      logic [31:0] c = 32'hFFFFFFFF;
      for (int b = 0; b < 6; b++) begin
         logic [7:0] d = a[47 - 8*b -: 8];
         for (int j = 0; j < 8; j++) begin
            logic f = c[0] ^ d[j];
            c = c >> 1;
            if (f) c = c ^ 32'hEDB88320;
         end
      end
      return c[31:26];
   endfunction

   function automatic logic ref_accept(input logic [47:0] a, input logic [63:0] t,
                                       input logic h, input logic p);
      return p | (a[40] & h & t[ref_idx(a)]);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic write_table(input logic [63:0] t);
      for (int w = 0; w < 4; w++) begin
         @(negedge clk);
         tbl_we = 1'b1; tbl_sel = 2'(w); tbl_wdata = t[16*w +: 16];
      end
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   // drives six bytes and samples the decision on the falling edge after the sixth
   task automatic send_frame(input logic [47:0] a, input logic h, input logic p,
                             output logic v, output logic acc, output logic grp, output logic early);
      early = 1'b0;
      for (int b = 0; b < 6; b++) begin
         @(negedge clk);
         if (dec_valid) early = 1'b1;
         addr_vld = 1'b1; addr_sof = (b == 0); addr_byte = a[47 - 8*b -: 8];
         if (b == 0) begin cfg_hash_en = h; cfg_promisc = p; end
      end
      @(negedge clk);
      addr_vld = 1'b0; addr_sof = 1'b0;
      v = dec_valid; acc = dec_accept; grp = dec_group;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic v, acc, grp, early;
      logic [47:0] ga;
      logic [5:0]  gi;
      rst_n = 1'b0; addr_vld = 1'b0; addr_sof = 1'b0; addr_byte = '0;
      cfg_hash_en = 1'b0; cfg_promisc = 1'b0;
      tbl_we = 1'b0; tbl_sel = '0; tbl_wdata = '0;
      repeat (3) @(negedge clk);
      check("R12 reset dec_valid", 32'(dec_valid), 0);
      check("R12 reset dec_accept", 32'(dec_accept), 0);
      rst_n = 1'b1;

      // R12: table is zero after reset, so a hashed group address is rejected
      send_frame(48'h01005E000001, 1'b1, 1'b0, v, acc, grp, early);
      check("R12 reset table rejects group", 32'({v, acc}), 32'b10);

      // vector table: R1 R2 R3 R4 R5 R6 R7 R8 R9
      for (int n = 0; n < NV; n++) begin
         logic [47:0] a = VEC[n][113:66];
         logic [63:0] t = VEC[n][65:2];
         logic h = VEC[n][1];
         logic p = VEC[n][0];
         write_table(t);
         send_frame(a, h, p, v, acc, grp, early);
         check("R1 no strobe before sixth byte", 32'(early), 0);
         check("R1 strobe after sixth byte", 32'(v), 1);
         check("R2 R3 R5 R6 R7 R8 R9 accept", 32'(acc), 32'(ref_accept(a, t, h, p)));
         check("R4 group flag", 32'(grp), 32'(a[40]));
         @(negedge clk);
         check("R1 strobe one cycle", 32'(dec_valid), 0);
      end

      // R10: a write during a frame applies only to the next frame
      ga = 48'h01005E0000FB;
      gi = ref_idx(ga);
      write_table(64'h0);
      for (int b = 0; b < 6; b++) begin
         @(negedge clk);
         addr_vld = 1'b1; addr_sof = (b == 0); addr_byte = ga[47 - 8*b -: 8];
         if (b == 0) begin cfg_hash_en = 1'b1; cfg_promisc = 1'b0; end
         tbl_we = (b == 2); tbl_sel = gi[5:4]; tbl_wdata = 16'hFFFF;
      end
      @(negedge clk);
      addr_vld = 1'b0; addr_sof = 1'b0; tbl_we = 1'b0;
      check("R10 mid-frame write ignored", 32'({dec_valid, dec_accept}), 32'b10);
      send_frame(ga, 1'b1, 1'b0, v, acc, grp, early);
      check("R10 write used by next frame", 32'({v, acc}), 32'b11);

      // R10: config change during a frame does not affect that frame
      write_table(64'h0);
      for (int b = 0; b < 6; b++) begin
         @(negedge clk);
         addr_vld = 1'b1; addr_sof = (b == 0); addr_byte = ga[47 - 8*b -: 8];
         cfg_hash_en = 1'b1; cfg_promisc = (b != 0);
      end
      @(negedge clk);
      addr_vld = 1'b0; cfg_promisc = 1'b0;
      check("R10 promisc sampled at start", 32'({dec_valid, dec_accept}), 32'b10);

      // R11: trailing bytes produce no decision
      for (int k = 0; k < 3; k++) begin
         addr_vld = 1'b1; addr_sof = 1'b0; addr_byte = 8'h5A;
         @(negedge clk);
         check("R11 trailing byte ignored", 32'(dec_valid), 0);
      end
      addr_vld = 1'b0;

      // R11: a start strobe partway through restarts the address
      write_table(64'hFFFF_FFFF_FFFF_FFFF);
      for (int b = 0; b < 3; b++) begin
         @(negedge clk);
         addr_vld = 1'b1; addr_sof = (b == 0); addr_byte = 8'h00;
         cfg_hash_en = 1'b1; cfg_promisc = 1'b0;
      end
      send_frame(48'h01005E000001, 1'b1, 1'b0, v, acc, grp, early);
      check("R11 restart no early decision", 32'(early), 0);
      check("R11 restart decision", 32'({v, acc, grp}), 32'b111);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule